// File: doc/BRIEF.md
# Queue Interrupt Cause Linked-List Engine

This block routes receive and transmit queue events to interrupt vectors. Each vector owns a singly linked list of queue control entries. A configuration port writes two kinds of register. The first is a list head for each vector, which names the first queue's index and type. The second is a control word for each RX and each TX queue. The control word holds the target vector, a moderation-timer index, a cause-enable bit, a vector-0 cause-bit selector, and a link to the next queue (index and type). A queue index of 0x7FF terminates a list.

When a queue event pulse arrives, the block reads that queue's control word. If the cause is enabled, it marks the target vector pending and reports the vector and the moderation index on the next cycle. Servicing logic acknowledges pending vectors with a clear mask. Events routed to vector 0 can also set one of seven cause bits, so that a single-vector system can tell the sources apart.

A walker traverses a chosen vector's list at one node per clock and reports each member queue, so that servicing can find every contributor. A list that does not terminate within twice the number of queues ends the walk with an error. A node that points at a queue which does not exist also ends the walk with an error.

Top module: `qint_list_engine`

## Requirements
- R1: After reset, no vector is pending, all vector-0 cause bits are clear, the walker is idle, every list head holds 0x7FF, and every queue's cause-enable bit is 0.
- R2: An event on a queue whose cause-enable bit (control-word bit 12) is set produces `pend_valid` on the next cycle. In that cycle `pend_vec` equals control bits [25:18] and `pend_itr` equals control bits [14:13]. The pending bit of that vector is also set.
- R3: An event on a queue whose cause-enable bit is clear has no effect: no `pend_valid`, no pending change and no cause-bit change. Rewriting the bit takes effect for later events.
- R4: A head write with `head_v0`=1 sets the list head of vector 0. Otherwise head number N sets the list head of vector N+1, and a write is ignored when N+1 is not below the vector count. The head word holds the index in bits [10:0] and the type in bit [11], where 0 means RX and 1 means TX.
- R5: A walk started on an idle walker presents the head node in the cycle after the start edge. Each later cycle presents the successor named by the current node's control word (bits [10:0] index, bit [11] type). The walk ends with a one-cycle `walk_done` in the cycle that would hold the end-of-list node.
- R6: A queue index of 0x7FF marks end-of-list. A vector whose head holds 0x7FF walks with zero nodes and signals `walk_done` in the first walk cycle.
- R7: A walk that has presented twice the number of queues without reaching end-of-list ends with `walk_err` and without `walk_done`. A node whose index is neither 0x7FF nor a valid queue also ends the walk with `walk_err`.
- R8: An accepted event that targets vector 0 and carries a selector (control bits [17:15]) below 7 sets `v0_cause` bit equal to that selector. A selector of 7 sets no bit. `v0_clr` clears all the cause bits, and a set in the same cycle wins over the clear.
- R9: A bit of `vec_ack` clears the pending bit of that vector. A new event for the same vector in the same cycle wins over the clear.
- R10: An event whose queue index is not below the queue count, or whose target vector is not below the vector count, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_we | input | 1 | List-head write strobe |
| head_v0 | input | 1 | 1: write targets the vector-0 head |
| head_num | input | 8 | Head number N (vector N+1) when head_v0 is 0 |
| head_wdata | input | 12 | {first type, first index} |
| qctl_we | input | 1 | Queue control write strobe |
| qctl_type | input | 1 | 0 RX, 1 TX queue entry |
| qctl_qidx | input | 11 | Queue index written |
| qctl_wdata | input | 26 | {vector, selector, moderation index, enable, next type, next index} |
| ev_valid | input | 1 | Queue event pulse |
| ev_type | input | 1 | Event queue type |
| ev_qidx | input | 11 | Event queue index |
| vec_ack | input | NV | Per-vector pending clear |
| v0_clr | input | 1 | Clears all vector-0 cause bits |
| pend_valid | output | 1 | An event was accepted last cycle |
| pend_vec | output | $clog2(NV) | Vector of the accepted event |
| pend_itr | output | 2 | Moderation index of the accepted event |
| vec_pending | output | NV | Pending flag per vector |
| v0_cause | output | 7 | Vector-0 cause bits |
| walk_start | input | 1 | Starts a walk when idle |
| walk_vec | input | $clog2(NV) | Vector whose list is walked |
| walk_busy | output | 1 | Walker active |
| node_valid | output | 1 | A list node is presented |
| node_type | output | 1 | Type of the presented node |
| node_qidx | output | 11 | Index of the presented node |
| walk_done | output | 1 | Walk reached end-of-list |
| walk_err | output | 1 | Walk aborted: loop bound or bad index |

## Verification
A misprogrammed cyclic list is the hardest case to reach, since ordinary programming always terminates. The bench rewrites one TX entry so that it points back at the RX queue of its own pair. It then walks that vector and expects exactly twice-the-queue-count nodes followed by the error pulse. A second rewrite points a link at a nonexistent queue. Random events mixed with random reprogramming of enable, target vector and selector fields also hit same-cycle collisions of sets with acknowledges and cause clears.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int QIDX_W = 11;
  localparam logic [QIDX_W-1:0] Q_EOL = 11'h7FF;
  localparam int VFLD_W = 8;

  typedef enum logic {QT_RX = 1'b0, QT_TX = 1'b1} qtype_e;

  typedef struct packed {
    qtype_e              ftype;
    logic [QIDX_W-1:0]   fidx;
  } qlink_t;

  typedef struct packed {
    logic [VFLD_W-1:0]   vec;
    logic [2:0]          slot;
    logic [1:0]          itr;
    logic                ena;
  } qcause_t;

  typedef struct packed {
    qcause_t cause;
    qlink_t  link;
  } qctl_t;

  localparam int LINK_W = $bits(qlink_t);
  localparam int CTL_W  = $bits(qctl_t);
endpackage

// File: rtl/qint_cfg_store.sv
module qint_cfg_store
  import qint_pkg::*;
#(
  parameter int NQ = 8,
  parameter int NV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_we,
  input  logic              head_v0,
  input  logic [7:0]        head_num,
  input  logic [LINK_W-1:0] head_wdata,
  input  logic              qctl_we,
  input  logic              qctl_type,
  input  logic [QIDX_W-1:0] qctl_qidx,
  input  logic [CTL_W-1:0]  qctl_wdata,
  output qctl_t             rx_ctl [NQ],
  output qctl_t             tx_ctl [NQ],
  output qlink_t            heads  [NV]
);
  localparam qlink_t EMPTY_LINK = '{ftype: QT_RX, fidx: Q_EOL};
  localparam qctl_t  RST_CTL    = '{cause: '0, link: EMPTY_LINK};

  logic [8:0] head_tgt;
  always_comb head_tgt = head_v0 ? 9'd0 : ({1'b0, head_num} + 9'd1);

  for (genvar v = 0; v < NV; v++) begin : g_head
    logic   hd_en;
    qlink_t hd_d;
    always_comb begin
      hd_en = head_we && (head_tgt == 9'(v));
      hd_d  = hd_en ? qlink_t'(head_wdata) : heads[v];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) heads[v] <= EMPTY_LINK;
      else        heads[v] <= hd_d;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic  rx_en, tx_en;
    qctl_t rx_d, tx_d;
    always_comb begin
      rx_en = qctl_we && (qctl_qidx == QIDX_W'(q)) && (qctl_type == QT_RX);
      tx_en = qctl_we && (qctl_qidx == QIDX_W'(q)) && (qctl_type == QT_TX);
      rx_d  = rx_en ? qctl_t'(qctl_wdata) : rx_ctl[q];
      tx_d  = tx_en ? qctl_t'(qctl_wdata) : tx_ctl[q];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_ctl[q] <= RST_CTL;
        tx_ctl[q] <= RST_CTL;
      end else begin
        rx_ctl[q] <= rx_d;
        tx_ctl[q] <= tx_d;
      end
    end
  end
endmodule

// File: rtl/qint_event_map.sv
module qint_event_map
  import qint_pkg::*;
#(
  parameter int NQ = 8,
  parameter int NV = 4,
  localparam int VEC_W = $clog2(NV),
  localparam int QI_W  = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_type,
  input  logic [QIDX_W-1:0] ev_qidx,
  input  qcause_t           rx_c [NQ],
  input  qcause_t           tx_c [NQ],
  input  logic [NV-1:0]     vec_ack,
  input  logic              v0_clr,
  output logic              pend_valid,
  output logic [VEC_W-1:0]  pend_vec,
  output logic [1:0]        pend_itr,
  output logic [NV-1:0]     vec_pending,
  output logic [6:0]        v0_cause
);
  qcause_t          sel;
  logic             hit;
  logic [NV-1:0]    set_vec;
  logic [NV-1:0]    pend_d;
  logic [6:0]       cause_d;

  always_comb begin
    sel     = (ev_type == QT_TX) ? tx_c[ev_qidx[QI_W-1:0]] : rx_c[ev_qidx[QI_W-1:0]];
    hit     = ev_valid && (int'(ev_qidx) < NQ) && sel.ena && (int'(sel.vec) < NV);
    set_vec = hit ? (NV'(1) << sel.vec[VEC_W-1:0]) : '0;
    pend_d  = (vec_pending & ~vec_ack) | set_vec;
    cause_d = v0_clr ? 7'd0 : v0_cause;
    for (int b = 0; b < 7; b++)
      if (hit && (sel.vec == '0) && (sel.slot == 3'(b))) cause_d[b] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid  <= 1'b0;
      pend_vec    <= '0;
      pend_itr    <= '0;
      vec_pending <= '0;
      v0_cause    <= '0;
    end else begin
      pend_valid  <= hit;
      if (hit) begin
        pend_vec <= sel.vec[VEC_W-1:0];
        pend_itr <= sel.itr;
      end
      vec_pending <= pend_d;
      v0_cause    <= cause_d;
    end
  end

  // R2: a reported vector is pending in the same cycle
  a_r2_reported_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> vec_pending[pend_vec]);
  // R3: no report without an event pulse the cycle before
  a_r3_no_spurious_report: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> $past(ev_valid));
  // R8: cause bits move only on an event or a clear
  a_r8_cause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !v0_clr) |=> $stable(v0_cause));
  for (genvar v = 0; v < NV; v++) begin : g_ack_chk
    // R9: acknowledge without a fresh set clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack[v] && !set_vec[v]) |=> !vec_pending[v]);
  end
endmodule

// File: rtl/qint_list_walker.sv
module qint_list_walker
  import qint_pkg::*;
#(
  parameter int NQ = 8,
  parameter int NV = 4,
  localparam int VEC_W = $clog2(NV),
  localparam int QI_W  = $clog2(NQ),
  localparam int LIMIT = 2 * NQ,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [VEC_W-1:0]  walk_vec,
  input  qlink_t            heads  [NV],
  input  qlink_t            rx_lnk [NQ],
  input  qlink_t            tx_lnk [NQ],
  output logic              walk_busy,
  output logic              node_valid,
  output logic              node_type,
  output logic [QIDX_W-1:0] node_qidx,
  output logic              walk_done,
  output logic              walk_err
);
  logic             run_q, run_d;
  qlink_t           cur_q, cur_d, succ;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_eol, bad;

  always_comb begin
    is_eol = (cur_q.fidx == Q_EOL);
    bad    = !is_eol && ((int'(cur_q.fidx) >= NQ) || (cnt_q == CNT_W'(LIMIT)));
    succ   = (cur_q.ftype == QT_TX) ? tx_lnk[cur_q.fidx[QI_W-1:0]]
                                    : rx_lnk[cur_q.fidx[QI_W-1:0]];
    node_valid = run_q && !is_eol && !bad;
    walk_done  = run_q && is_eol;
    walk_err   = run_q && bad;
    run_d = run_q;
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      if (walk_start && (int'(walk_vec) < NV)) begin
        run_d = 1'b1;
        cur_d = heads[walk_vec];
        cnt_d = '0;
      end
    end else if (is_eol || bad) begin
      run_d = 1'b0;
    end else begin
      cur_d = succ;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cur_q <= '{ftype: QT_RX, fidx: Q_EOL};
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign walk_busy = run_q;
  assign node_type = cur_q.ftype;
  assign node_qidx = cur_q.fidx;

  // R5: at most one walk outcome per cycle
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({node_valid, walk_done, walk_err}));
  // R6: end-of-list returns the walker to idle
  a_r6_done_idles: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_busy);
  // R7: the node counter never passes the loop bound
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LIMIT);
  // R7: an error ends the walk
  a_r7_err_idles: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |=> !walk_busy);
endmodule

// File: rtl/qint_list_engine.sv
module qint_list_engine
  import qint_pkg::*;
#(
  parameter int NQ = 8,
  parameter int NV = 4,
  localparam int VEC_W = $clog2(NV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_we,
  input  logic              head_v0,
  input  logic [7:0]        head_num,
  input  logic [11:0]       head_wdata,
  input  logic              qctl_we,
  input  logic              qctl_type,
  input  logic [10:0]       qctl_qidx,
  input  logic [25:0]       qctl_wdata,
  input  logic              ev_valid,
  input  logic              ev_type,
  input  logic [10:0]       ev_qidx,
  input  logic [NV-1:0]     vec_ack,
  input  logic              v0_clr,
  output logic              pend_valid,
  output logic [VEC_W-1:0]  pend_vec,
  output logic [1:0]        pend_itr,
  output logic [NV-1:0]     vec_pending,
  output logic [6:0]        v0_cause,
  input  logic              walk_start,
  input  logic [VEC_W-1:0]  walk_vec,
  output logic              walk_busy,
  output logic              node_valid,
  output logic              node_type,
  output logic [10:0]       node_qidx,
  output logic              walk_done,
  output logic              walk_err
);
  qctl_t   rx_ctl [NQ];
  qctl_t   tx_ctl [NQ];
  qlink_t  heads  [NV];
  qcause_t rx_c   [NQ];
  qcause_t tx_c   [NQ];
  qlink_t  rx_lnk [NQ];
  qlink_t  tx_lnk [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_split
    assign rx_c[q]   = rx_ctl[q].cause;
    assign tx_c[q]   = tx_ctl[q].cause;
    assign rx_lnk[q] = rx_ctl[q].link;
    assign tx_lnk[q] = tx_ctl[q].link;
  end

  qint_cfg_store #(.NQ(NQ), .NV(NV)) u_store (
    .clk(clk), .rst_n(rst_n),
    .head_we(head_we), .head_v0(head_v0), .head_num(head_num), .head_wdata(head_wdata),
    .qctl_we(qctl_we), .qctl_type(qctl_type), .qctl_qidx(qctl_qidx), .qctl_wdata(qctl_wdata),
    .rx_ctl(rx_ctl), .tx_ctl(tx_ctl), .heads(heads)
  );

  qint_event_map #(.NQ(NQ), .NV(NV)) u_map (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_type(ev_type), .ev_qidx(ev_qidx),
    .rx_c(rx_c), .tx_c(tx_c), .vec_ack(vec_ack), .v0_clr(v0_clr),
    .pend_valid(pend_valid), .pend_vec(pend_vec), .pend_itr(pend_itr),
    .vec_pending(vec_pending), .v0_cause(v0_cause)
  );

  qint_list_walker #(.NQ(NQ), .NV(NV)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .walk_start(walk_start), .walk_vec(walk_vec),
    .heads(heads), .rx_lnk(rx_lnk), .tx_lnk(tx_lnk),
    .walk_busy(walk_busy), .node_valid(node_valid), .node_type(node_type),
    .node_qidx(node_qidx), .walk_done(walk_done), .walk_err(walk_err)
  );
endmodule

// File: tb/qint_list_engine_tb_top.sv
`timescale 1ns/1ps
module qint_list_engine_tb_top;
  localparam int NQ = 8;
  localparam int NV = 4;
  localparam int LIM = 2 * NQ;
  localparam logic [10:0] EOL = 11'h7FF;

  logic clk, rst_n;
  logic head_we, head_v0;
  logic [7:0] head_num;
  logic [11:0] head_wdata;
  logic qctl_we, qctl_type;
  logic [10:0] qctl_qidx;
  logic [25:0] qctl_wdata;
  logic ev_valid, ev_type;
  logic [10:0] ev_qidx;
  logic [NV-1:0] vec_ack;
  logic v0_clr;
  logic pend_valid;
  logic [1:0] pend_vec;
  logic [1:0] pend_itr;
  logic [NV-1:0] vec_pending;
  logic [6:0] v0_cause;
  logic walk_start;
  logic [1:0] walk_vec;
  logic walk_busy, node_valid, node_type, walk_done, walk_err;
  logic [10:0] node_qidx;

  int total = 0;
  int bad = 0;

  logic [25:0] m_rx [NQ];
  logic [25:0] m_tx [NQ];
  logic [11:0] m_head [NV];
  logic [NV-1:0] m_pend;
  logic [6:0] m_cause;

  qint_list_engine #(.NQ(NQ), .NV(NV)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input int vec, input int slot, input int itr,
                                     input bit ena, input bit nt, input logic [10:0] ni);
    return {8'(vec), 3'(slot), 2'(itr), ena, nt, ni};
  endfunction

  task automatic wr_ctl(input bit t, input int q, input logic [25:0] w);
    @(negedge clk);
    qctl_we = 1; qctl_type = t; qctl_qidx = 11'(q); qctl_wdata = w;
    @(posedge clk); #1;
    qctl_we = 0;
    if (q < NQ) begin
      if (t) m_tx[q] = w; else m_rx[q] = w;
    end
  endtask

  task automatic wr_head(input bit v0, input int num, input logic [11:0] w);
    int tgt;
    @(negedge clk);
    head_we = 1; head_v0 = v0; head_num = 8'(num); head_wdata = w;
    @(posedge clk); #1;
    head_we = 0;
    tgt = v0 ? 0 : num + 1;
    if (tgt < NV) m_head[tgt] = w;
  endtask

  task automatic ev_step(input bit v, input bit t, input int q, input logic [NV-1:0] ack,
                         input bit clr, input string tag);
    logic [25:0] w;
    bit hit;
    @(negedge clk);
    ev_valid = v; ev_type = t; ev_qidx = 11'(q); vec_ack = ack; v0_clr = clr;
    w = (q < NQ) ? (t ? m_tx[q] : m_rx[q]) : 26'd0;
    hit = v && (q < NQ) && w[12] && (w[25:18] < NV);
    m_pend = (m_pend & ~ack);
    if (clr) m_cause = '0;
    if (hit) begin
      m_pend[w[19:18]] = 1'b1;
      if (w[25:18] == 0 && w[17:15] != 3'd7) m_cause[w[17:15]] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    ev_valid = 0; vec_ack = '0; v0_clr = 0;
    if (hit)
      chk(pend_valid && pend_vec == w[19:18] && pend_itr == w[14:13], {tag, " report"},
          {pend_valid, pend_vec, pend_itr}, {1'b1, w[19:18], w[14:13]});
    else
      chk(!pend_valid, {tag, " no report"}, 32'(pend_valid), 0);
    chk(vec_pending == m_pend, {tag, " pending"}, 32'(vec_pending), 32'(m_pend));
    chk(v0_cause == m_cause, {tag, " cause"}, 32'(v0_cause), 32'(m_cause));
  endtask

  task automatic walk_chk(input int v, input string tag);
    logic [11:0] cur;
    int cnt;
    bit fin;
    @(negedge clk);
    walk_start = 1; walk_vec = 2'(v);
    @(posedge clk);
    @(negedge clk);
    walk_start = 0;
    cur = m_head[v]; cnt = 0; fin = 0;
    while (!fin) begin
      if (cur[10:0] == EOL) begin
        chk(walk_done && !walk_err && !node_valid, {tag, " end"},
            {walk_done, walk_err, node_valid}, 3'b100);
        fin = 1;
      end else if (cur[10:0] >= NQ || cnt == LIM) begin
        chk(walk_err && !walk_done && !node_valid, {tag, " abort"},
            {walk_done, walk_err, node_valid}, 3'b010);
        fin = 1;
      end else begin
        chk(node_valid && node_qidx == cur[10:0] && node_type == cur[11], {tag, " node"},
            {node_valid, node_type, node_qidx}, {1'b1, cur});
        cur = cur[11] ? m_tx[cur[10:0]][11:0] : m_rx[cur[10:0]][11:0];
        cnt++;
        @(posedge clk);
        @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(!walk_busy, {tag, " idle after"}, 32'(walk_busy), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    head_we = 0; head_v0 = 0; head_num = 0; head_wdata = 0;
    qctl_we = 0; qctl_type = 0; qctl_qidx = 0; qctl_wdata = 0;
    ev_valid = 0; ev_type = 0; ev_qidx = 0; vec_ack = 0; v0_clr = 0;
    walk_start = 0; walk_vec = 0;
    for (int q = 0; q < NQ; q++) begin
      m_rx[q] = {14'd0, 1'b0, EOL};
      m_tx[q] = {14'd0, 1'b0, EOL};
    end
    for (int v = 0; v < NV; v++) m_head[v] = {1'b0, EOL};
    m_pend = '0; m_cause = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(vec_pending == 0 && v0_cause == 0 && !walk_busy && !pend_valid, "R1 reset outputs",
        {vec_pending, v0_cause, walk_busy, pend_valid}, 0);
    walk_chk(1, "R1 R6 empty list after reset");
    ev_step(1, 0, 2, '0, 0, "R1 R3 event with reset enable clear");

    // R4 R5: program lists: queue q on vector (q%3)+1, rx q -> tx q -> rx q+3
    for (int q = 0; q < NQ; q++) begin
      int v;
      v = (q % 3) + 1;
      wr_ctl(0, q, mk(v, 7, 0, 1, 1, 11'(q)));
      wr_ctl(1, q, mk(v, 7, 1, 1, 0, (q + 3 < NQ) ? 11'(q + 3) : EOL));
    end
    for (int v = 1; v < NV; v++) wr_head(0, v - 1, {1'b0, 11'(v - 1)});
    wr_head(0, 3, {1'b0, 11'd5});  // R4: vector 4 does not exist, ignored
    for (int v = 1; v < NV; v++) walk_chk(v, "R5 R4 walk programmed list");
    walk_chk(0, "R4 R6 vector 0 still empty");

    // R2 directed
    ev_step(1, 0, 4, '0, 0, "R2 rx event vector 2");
    ev_step(1, 1, 4, '0, 0, "R2 tx event itr 1");
    // R9 set wins over ack
    ev_step(1, 0, 4, 4'b0100, 0, "R9 set beats ack");
    ev_step(0, 0, 0, 4'b1111, 0, "R9 ack clears");
    // R3 toggle enable
    wr_ctl(0, 5, mk(3, 7, 0, 0, 1, 11'd5));
    ev_step(1, 0, 5, '0, 0, "R3 masked queue");
    wr_ctl(0, 5, mk(3, 7, 0, 1, 1, 11'd5));
    ev_step(1, 0, 5, '0, 0, "R3 unmasked queue");
    // R10 out-of-range index and vector
    ev_step(1, 1, 9, '0, 0, "R10 index out of range");
    wr_ctl(1, 6, mk(4, 7, 1, 1, 0, EOL));
    ev_step(1, 1, 6, '0, 0, "R10 vector out of range");
    // R8 vector-0 cause bits
    wr_ctl(0, 0, mk(0, 0, 0, 1, 1, 11'd0));
    wr_ctl(1, 0, mk(0, 1, 1, 1, 0, EOL));
    wr_ctl(0, 1, mk(0, 7, 0, 1, 1, 11'd1));
    ev_step(1, 0, 0, '0, 0, "R8 selector 0");
    ev_step(1, 1, 0, '0, 0, "R8 selector 1");
    ev_step(1, 0, 1, '0, 0, "R8 selector 7 sets nothing");
    ev_step(1, 0, 0, '0, 1, "R8 set beats clear");
    ev_step(0, 0, 0, 4'b0001, 1, "R8 clear");
    wr_head(1, 0, {1'b0, 11'd0});
    walk_chk(0, "R4 vector 0 head");

    // random mix R2 R3 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 5) == 0) begin
        int q;
        bit t;
        logic [25:0] w;
        q = $urandom_range(0, NQ - 1);
        t = 1'($urandom_range(0, 1));
        w = t ? m_tx[q] : m_rx[q];
        wr_ctl(t, q, mk($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 3),
                        ($urandom_range(0, 3) != 0), w[11], w[10:0]));
      end else begin
        ev_step(($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), $urandom_range(0, 9),
                ($urandom_range(0, 3) == 0) ? NV'($urandom) : '0,
                ($urandom_range(0, 7) == 0), "R2 R3 R8 R9 R10 random");
      end
    end

    // R7: cyclic list through tx 1 -> rx 1
    wr_ctl(1, 1, mk(2, 7, 1, 1, 0, 11'd1));
    walk_chk(2, "R7 cyclic list");
    // R7: link to nonexistent queue
    wr_ctl(1, 1, mk(2, 7, 1, 1, 0, 11'd9));
    walk_chk(2, "R7 bad index");
    // R6: head emptied with end-of-list value
    wr_head(0, 1, {1'b0, EOL});
    walk_chk(2, "R6 emptied head");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule